// File: doc/BRIEF.md
# USB Debug Transaction Engine

This block carries out one USB transaction at a time on behalf of a software debug channel. Software fills a small register set: the token PID, the outgoing data PID, an 8-byte data buffer, the target device address and endpoint, a direction bit and a byte count. It then sets the go bit. The engine sends a token packet. For a write it follows the token with a data packet and waits for a one-byte handshake. For a read it waits for either a data packet or a one-byte handshake. When the exchange ends, the engine clears go. The received PID, the error flag and, on reads, the received byte count and buffer contents are then valid.

The line side is a byte stream in each direction, with first-byte and last-byte markers per packet. Both streams use valid/ready. On the transmit stream, once the engine raises `tx_valid` it holds the byte and both markers steady until `tx_ready` is seen high at a clock edge. The sink may hold `tx_ready` low for any number of cycles. On the receive stream, the engine raises `rx_ready` only while it is waiting for the device's response. A source offering bytes at any other time is stalled, not dropped. Bit stuffing, NRZI, line states and retries belong to the layer below.

Top module: `usbdbg_xact_engine`

## Requirements
- R1: After reset the device register (address 4) reads 0x0000017F: device address 7Fh in bits 6:0 and endpoint 1 in bits 11:8. Every other register address reads zero.
- R2: Register map. Address 0 is control: bit 0 go, bit 1 direction (1 = write), bits 7:4 length, bit 8 error (read-only). Address 1 holds PIDs: bits 7:0 token PID, bits 15:8 send PID, bits 23:16 received PID (read-only). Addresses 2 and 3 hold buffer bytes 0-3 and 4-7, with byte k of each word in bits 8k+7:8k. Address 4 is the device register. Unlisted bits read zero and ignore writes. All register writes are ignored while go reads 1.
- R3: Writing control with bit 0 set starts a transaction and clears the error flag. Go reads 1 until the transaction finishes and then returns to 0.
- R4: Each transaction begins with a 3-byte token packet. Byte 0 is the token PID. Byte 1 is {endpoint[0], address[6:0]}. Byte 2 is {crc5 field, endpoint[3:1]}. The CRC5 uses the polynomial x^5+x^2+1, preset to all ones, and is fed with address bit 0 first and then endpoint bit 0 first. Its complement is placed in bits 7:3 with the register's top bit at bit 3.
- R5: On a write, a data packet follows the token. It carries the send PID, then `length` buffer bytes from byte 0 upward, then two CRC16 bytes. The CRC16 uses polynomial 0x8005, is preset to all ones, is fed LSB first, and is sent complemented with the register's top bit first. A length of 9 to 15 written to control is stored as 8.
- R6: A write finishes on a one-byte handshake. Its PID is stored in the received-PID field, the error flag stays clear, and the length is unchanged.
- R7: A read answered by a data packet (PID low bits 11, 3 to 11 bytes long) stores that PID and writes the payload bytes into the buffer from byte 0 upward. Length is set to the packet size minus 3, so the two CRC bytes are not counted.
- R8: A read answered by a one-byte handshake (PID low bits 10, for example NAK 0x5A) stores that PID and sets length to 0 without error.
- R9: The error flag is set and go is cleared in three cases: the received PID's upper nibble is not the complement of its lower nibble; a write's response is not a one-byte handshake; or a read's data packet is shorter than 3 or longer than 11 bytes.
- R10: If no response byte arrives within TIMEOUT_CYCLES cycles of waiting, the engine sets the error flag, clears go and leaves the received-PID field unchanged.
- R11: Stream rules. A transmit byte holds steady while `tx_ready` is low. `tx_first` marks the first byte of each packet and `tx_last` marks its last byte. `rx_ready` is high only while go is set, and never while the engine is transmitting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | Transmit byte is first of its packet |
| tx_last | output | 1 | Transmit byte is last of its packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_first | input | 1 | Receive byte is first of its packet |
| rx_last | input | 1 | Receive byte is last of its packet |

## Verification
The response-timeout path and the malformed-response paths are the hardest to reach, because a well-behaved device never produces them. The bench reaches them by holding the receive stream silent after a read token, and by handing back a handshake with a broken complement nibble or a data packet one byte too long. It then checks that the received PID is left as it was or is captured, as each requirement demands. Register writes are also tried in the middle of a transaction, while go is held, and are then read back to show they had no effect. Write lengths 0 to 8 and read payloads 0 to 8 are swept with a pseudo-random transmit back-pressure pattern. Every byte and marker is compared against CRC values the bench computes with a reflected bit-serial form.

// File: rtl/usbdbg_pkg.sv
package usbdbg_pkg;
  localparam int BUF_BYTES = 8;
  localparam int LEN_W     = $clog2(BUF_BYTES + 1);
  localparam int BIDX_W    = $clog2(BUF_BYTES);
  localparam int RX_CNT_W  = $clog2(BUF_BYTES + 4) + 1;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_PID   = 3'd1;
  localparam logic [2:0] RA_BUFLO = 3'd2;
  localparam logic [2:0] RA_BUFHI = 3'd3;
  localparam logic [2:0] RA_DEV   = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_TOKEN, ST_DATA, ST_WAIT} eng_state_t;

  // Token check field: complemented CRC5, bit order reversed for the wire.
  function automatic logic [4:0] crc5_field(input logic [6:0] adr, input logic [3:0] ep);
    logic [4:0]  c;
    logic [10:0] d;
    logic [4:0]  res;
    logic        fb;
    c = '1;
    d = {ep, adr};
    for (int i = 0; i < 11; i++) begin
      fb = c[4] ^ d[i];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    c = ~c;
    for (int i = 0; i < 5; i++) res[i] = c[4-i];
    return res;
  endfunction

  function automatic logic [15:0] crc16_byte(input logic [15:0] cin, input logic [7:0] b);
    logic [15:0] c;
    logic        fb;
    c = cin;
    for (int i = 0; i < 8; i++) begin
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  function automatic logic [15:0] crc16_wire(input logic [15:0] c);
    logic [15:0] n;
    logic [15:0] res;
    n = ~c;
    for (int i = 0; i < 16; i++) res[i] = n[15-i];
    return res;
  endfunction
endpackage

// File: rtl/usbdbg_regs.sv
module usbdbg_regs
  import usbdbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              busy,
  output logic              dir_wr,
  output logic              err_flag,
  output logic [LEN_W-1:0]  len,
  output logic [7:0]        tok_pid,
  output logic [7:0]        snd_pid,
  output logic [6:0]        dev_addr,
  output logic [3:0]        dev_ep,
  output logic [7:0]        buf_bytes [BUF_BYTES],
  input  logic              fin,
  input  logic              fin_err,
  input  logic              fin_pid_we,
  input  logic [7:0]        fin_pid,
  input  logic              fin_len_we,
  input  logic [LEN_W-1:0]  fin_len,
  input  logic              bw_en,
  input  logic [BIDX_W-1:0] bw_idx,
  input  logic [7:0]        bw_data
);
  logic [7:0]       rcv_pid;
  logic [LEN_W-1:0] len_sat;

  assign len_sat = (reg_wdata[7:4] > 4'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : LEN_W'(reg_wdata[7:4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dir_wr   <= 1'b0;
      err_flag <= 1'b0;
      len      <= '0;
      tok_pid  <= '0;
      snd_pid  <= '0;
      rcv_pid  <= '0;
      dev_addr <= 7'h7F;
      dev_ep   <= 4'h1;
      for (int i = 0; i < BUF_BYTES; i++) buf_bytes[i] <= '0;
    end else begin
      if (reg_wr && !busy) begin
        unique case (reg_addr)
          RA_CTRL: begin
            dir_wr <= reg_wdata[1];
            len    <= len_sat;
            if (reg_wdata[0]) begin
              busy     <= 1'b1;
              err_flag <= 1'b0;
            end
          end
          RA_PID: begin
            tok_pid <= reg_wdata[7:0];
            snd_pid <= reg_wdata[15:8];
          end
          RA_BUFLO: for (int i = 0; i < 4; i++) buf_bytes[i] <= reg_wdata[8*i +: 8];
          RA_BUFHI: for (int i = 0; i < 4; i++) buf_bytes[4+i] <= reg_wdata[8*i +: 8];
          RA_DEV: begin
            dev_addr <= reg_wdata[6:0];
            dev_ep   <= reg_wdata[11:8];
          end
          default: ;
        endcase
      end
      if (bw_en) buf_bytes[bw_idx] <= bw_data;
      if (fin) begin
        busy     <= 1'b0;
        err_flag <= fin_err;
        if (fin_pid_we) rcv_pid <= fin_pid;
        if (fin_len_we) len <= fin_len;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:  reg_rdata = {23'd0, err_flag, 4'(len), 2'b00, dir_wr, busy};
      RA_PID:   reg_rdata = {8'd0, rcv_pid, snd_pid, tok_pid};
      RA_BUFLO: reg_rdata = {buf_bytes[3], buf_bytes[2], buf_bytes[1], buf_bytes[0]};
      RA_BUFHI: reg_rdata = {buf_bytes[7], buf_bytes[6], buf_bytes[5], buf_bytes[4]};
      RA_DEV:   reg_rdata = {20'd0, dev_ep, 1'b0, dev_addr};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usbdbg_tx.sv
module usbdbg_tx
  import usbdbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_data,
  input  logic [7:0]       tok_pid,
  input  logic [7:0]       snd_pid,
  input  logic [6:0]       dev_addr,
  input  logic [3:0]       dev_ep,
  input  logic [7:0]       buf_bytes [BUF_BYTES],
  input  logic [LEN_W-1:0] len,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_first,
  output logic             tx_last,
  output logic             done
);
  localparam int IDX_W = $clog2(BUF_BYTES + 3);

  logic             active;
  logic             data_mode;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [15:0]      crc;
  logic [IDX_W-1:0] len_x;
  logic [BIDX_W-1:0] sel;
  logic [4:0]       c5;
  logic [15:0]      crc_w;
  logic             fire;
  logic             is_payload;

  assign len_x      = IDX_W'(len);
  assign sel        = BIDX_W'(idx - IDX_W'(1));
  assign c5         = crc5_field(dev_addr, dev_ep);
  assign crc_w      = crc16_wire(crc);
  assign tx_valid   = active;
  assign fire       = active && tx_ready;
  assign tx_first   = active && (idx == '0);
  assign tx_last    = active && (idx == last_idx);
  assign done       = fire && (idx == last_idx);
  assign is_payload = data_mode && (idx != '0) && (idx <= len_x);

  always_comb begin
    if (!data_mode) begin
      unique case (idx)
        IDX_W'(0): tx_data = tok_pid;
        IDX_W'(1): tx_data = {dev_ep[0], dev_addr};
        default:   tx_data = {c5, dev_ep[3:1]};
      endcase
    end else if (idx == '0) begin
      tx_data = snd_pid;
    end else if (idx <= len_x) begin
      tx_data = buf_bytes[sel];
    end else if (idx == len_x + IDX_W'(1)) begin
      tx_data = crc_w[7:0];
    end else begin
      tx_data = crc_w[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      data_mode <= 1'b0;
      idx       <= '0;
      last_idx  <= '0;
      crc       <= '1;
    end else begin
      if (fire) begin
        if (is_payload) crc <= crc16_byte(crc, tx_data);
        if (idx == last_idx) active <= 1'b0;
        else idx <= idx + IDX_W'(1);
      end
      if (start) begin
        active    <= 1'b1;
        data_mode <= start_data;
        idx       <= '0;
        crc       <= '1;
        last_idx  <= start_data ? len_x + IDX_W'(2) : IDX_W'(2);
      end
    end
  end
endmodule

// File: rtl/usbdbg_rx.sv
module usbdbg_rx
  import usbdbg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armed,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                rx_first,
  input  logic                rx_last,
  output logic                rx_ready,
  output logic                pkt_done,
  output logic [7:0]          pkt_pid,
  output logic [RX_CNT_W-1:0] pkt_len,
  output logic                bw_en,
  output logic [BIDX_W-1:0]   bw_idx,
  output logic [7:0]          bw_data
);
  logic [RX_CNT_W-1:0] cnt;
  logic [RX_CNT_W-1:0] cnt_inc;
  logic [7:0]          pid_q;
  logic                acc;
  logic                is_pid;

  assign rx_ready = armed;
  assign acc      = armed && rx_valid;
  assign is_pid   = rx_first || (cnt == '0);
  assign cnt_inc  = (cnt == '1) ? cnt : cnt + RX_CNT_W'(1);
  assign pkt_done = acc && rx_last;
  assign pkt_pid  = is_pid ? rx_data : pid_q;
  assign pkt_len  = is_pid ? RX_CNT_W'(1) : cnt_inc;
  assign bw_en    = acc && !is_pid && (cnt <= RX_CNT_W'(BUF_BYTES));
  assign bw_idx   = BIDX_W'(cnt - RX_CNT_W'(1));
  assign bw_data  = rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pid_q <= '0;
    end else if (!armed) begin
      cnt <= '0;
    end else if (acc) begin
      if (rx_last)     cnt <= '0;
      else if (is_pid) cnt <= RX_CNT_W'(1);
      else             cnt <= cnt_inc;
      if (is_pid) pid_q <= rx_data;
    end
  end
endmodule

// File: rtl/usbdbg_xact_engine.sv
module usbdbg_xact_engine
  import usbdbg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_first,
  input  logic        rx_last
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic              busy, dir_wr, err_flag;
  logic [LEN_W-1:0]  len;
  logic [7:0]        tok_pid, snd_pid;
  logic [6:0]        dev_addr;
  logic [3:0]        dev_ep;
  logic [7:0]        buf_bytes [BUF_BYTES];
  logic              fin, fin_err, fin_pid_we, fin_len_we;
  logic [LEN_W-1:0]  fin_len;
  logic              bw_en;
  logic [BIDX_W-1:0] bw_idx;
  logic [7:0]        bw_data;
  logic              tx_start, tx_start_data, tx_done;
  logic              armed, pkt_done;
  logic [7:0]        pkt_pid;
  logic [RX_CNT_W-1:0] pkt_len;
  eng_state_t        state, state_n;
  logic [TW-1:0]     timer;
  logic              pid_ok, hs_class, data_class, single, len_ok;

  usbdbg_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .busy, .dir_wr, .err_flag, .len, .tok_pid, .snd_pid, .dev_addr, .dev_ep,
    .buf_bytes, .fin, .fin_err, .fin_pid_we, .fin_pid(pkt_pid),
    .fin_len_we, .fin_len, .bw_en, .bw_idx, .bw_data
  );

  usbdbg_tx u_tx (
    .clk, .rst_n, .start(tx_start), .start_data(tx_start_data),
    .tok_pid, .snd_pid, .dev_addr, .dev_ep, .buf_bytes, .len,
    .tx_valid, .tx_ready, .tx_data, .tx_first, .tx_last, .done(tx_done)
  );

  usbdbg_rx u_rx (
    .clk, .rst_n, .armed, .rx_valid, .rx_data, .rx_first, .rx_last,
    .rx_ready, .pkt_done, .pkt_pid, .pkt_len, .bw_en, .bw_idx, .bw_data
  );

  assign pid_ok     = (pkt_pid[7:4] == ~pkt_pid[3:0]);
  assign hs_class   = (pkt_pid[1:0] == 2'b10);
  assign data_class = (pkt_pid[1:0] == 2'b11);
  assign single     = (pkt_len == RX_CNT_W'(1));
  assign len_ok     = (pkt_len >= RX_CNT_W'(3)) && (pkt_len <= RX_CNT_W'(BUF_BYTES + 3));

  always_comb begin
    state_n       = state;
    tx_start      = 1'b0;
    tx_start_data = 1'b0;
    armed         = 1'b0;
    fin           = 1'b0;
    fin_err       = 1'b0;
    fin_pid_we    = 1'b0;
    fin_len_we    = 1'b0;
    fin_len       = '0;
    unique case (state)
      ST_IDLE: if (busy) begin
        tx_start = 1'b1;
        state_n  = ST_TOKEN;
      end
      ST_TOKEN: if (tx_done) begin
        if (dir_wr) begin
          tx_start      = 1'b1;
          tx_start_data = 1'b1;
          state_n       = ST_DATA;
        end else begin
          state_n = ST_WAIT;
        end
      end
      ST_DATA: if (tx_done) state_n = ST_WAIT;
      ST_WAIT: begin
        armed = 1'b1;
        if (pkt_done) begin
          fin        = 1'b1;
          fin_pid_we = 1'b1;
          state_n    = ST_IDLE;
          if (dir_wr) begin
            fin_err = !(pid_ok && hs_class && single);
          end else if (data_class) begin
            fin_err    = !(pid_ok && len_ok);
            fin_len_we = !fin_err;
            fin_len    = LEN_W'(pkt_len - RX_CNT_W'(3));
          end else begin
            fin_err    = !(pid_ok && hs_class && single);
            fin_len_we = !fin_err;
          end
        end else if (timer == TW'(TIMEOUT_CYCLES - 1)) begin
          fin     = 1'b1;
          fin_err = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      state <= state_n;
      if (state != ST_WAIT || (rx_valid && rx_ready)) timer <= '0;
      else timer <= timer + TW'(1);
    end
  end
endmodule

// File: rtl/usbdbg_xact_chk.sv
module usbdbg_xact_chk
  import usbdbg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             err_flag,
  input logic [LEN_W-1:0] len,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_first,
  input logic             tx_last,
  input logic             rx_ready
);
  // R11: a stalled transmit byte and its markers hold
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last));

  // R11: receive side only open during a transaction, never while sending
  p_rx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> busy && !tx_valid);

  // R3: starting a transaction clears the error flag
  p_err_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err_flag);

  // R3: no packet traffic once go has dropped
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !rx_ready);

  // R5: stored length never exceeds the buffer size
  p_len_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LEN_W'(BUF_BYTES));
endmodule

bind usbdbg_xact_engine usbdbg_xact_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err_flag(err_flag), .len(len),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_first(tx_first), .tx_last(tx_last), .rx_ready(rx_ready)
);

// File: tb/usbdbg_xact_engine_test.sv
module usbdbg_xact_engine_test;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_first, tx_last, rx_ready;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;

  usbdbg_xact_engine #(.TIMEOUT_CYCLES(TMO)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] txq [0:31];
  logic       txf [0:31];
  logic       txl [0:31];
  int         txn = 0;
  logic       bp_mode = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic [7:0] pkt [0:15];

  always @(negedge clk) begin
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = bp_mode ? lfsr[0] : 1'b1;
    #1;
    if (tx_valid && tx_ready && txn < 32) begin
      txq[txn] = tx_data; txf[txn] = tx_first; txl[txn] = tx_last; txn++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #2 d = reg_rdata;
  endtask

  function automatic logic [7:0] tok_b2(input logic [6:0] a, input logic [3:0] e);
    logic [4:0]  r;
    logic [10:0] d;
    r = 5'h1F; d = {e, a};
    for (int i = 0; i < 11; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 5'h14) : (r >> 1);
    return {~r, e[3:1]};
  endfunction

  task automatic wait_tx(input int n);
    for (int i = 0; i < 3000 && txn < n; i++) @(negedge clk);
    chk("R11 tx byte count", 64'(txn), 64'(n));
  endtask

  task automatic wait_done();
    logic [31:0] d;
    d = 32'h1;
    for (int i = 0; i < 500 && d[0]; i++) rd(3'd0, d);
    chk("R3 go cleared at end", 64'(d[0]), 64'd0);
  endtask

  task automatic rx_pkt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pkt[i]; rx_first = (i == 0); rx_last = (i == n - 1);
      #1;
      for (int w = 0; w < 500 && !rx_ready; w++) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
  endtask

  task automatic check_token(input logic [7:0] tok, input logic [6:0] a, input logic [3:0] e);
    chk("R4 token pid", 64'(txq[0]), 64'(tok));
    chk("R4 token addr byte", 64'(txq[1]), 64'({e[0], a}));
    chk("R4 token crc5 byte", 64'(txq[2]), 64'(tok_b2(a, e)));
    chk("R11 token markers", 64'({txf[0], txl[0], txf[2], txl[2]}), 64'(4'b1001));
  endtask

  task automatic setup(input int k, input logic [7:0] tok, input logic [7:0] snd,
                       output logic [6:0] a, output logic [3:0] e);
    a = 7'(k * 37 + 5); e = 4'(k * 3 + 2);
    wr(3'd4, {20'd0, e, 1'b0, a});
    wr(3'd1, {16'd0, snd, tok});
  endtask

  task automatic do_write(input int k, input int len, input logic [7:0] resp, input bit exp_err);
    logic [6:0]  a;
    logic [3:0]  e;
    logic [7:0]  b [0:7];
    logic [7:0]  snd;
    logic [15:0] r;
    logic [31:0] d;
    snd = k[0] ? 8'h4B : 8'hC3;
    setup(k, 8'hE1, snd, a, e);
    for (int j = 0; j < 8; j++) b[j] = 8'(k * 16 + j * 7 + 3);
    wr(3'd2, {b[3], b[2], b[1], b[0]});
    wr(3'd3, {b[7], b[6], b[5], b[4]});
    txn = 0;
    wr(3'd0, 32'(len * 16 + 3));
    wait_tx(len + 6);
    check_token(8'hE1, a, e);
    chk("R5 data pid", 64'(txq[3]), 64'(snd));
    r = 16'hFFFF;
    for (int j = 0; j < len; j++) begin
      chk("R5 payload byte", 64'(txq[4 + j]), 64'(b[j]));
      for (int i = 0; i < 8; i++) r = (r[0] ^ b[j][i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    r = ~r;
    chk("R5 crc16 bytes", 64'({txq[len + 5], txq[len + 4]}), 64'(r));
    chk("R11 data markers", 64'({txf[3], txl[3], txf[len + 5], txl[len + 5]}), 64'(4'b1001));
    pkt[0] = resp;
    rx_pkt(1);
    wait_done();
    rd(3'd0, d);
    chk(exp_err ? "R9 write error flag" : "R6 write error flag", 64'(d[8]), 64'(exp_err));
    chk("R6 length unchanged", 64'(d[7:4]), 64'(len));
    rd(3'd1, d);
    chk("R6 handshake pid", 64'(d[23:16]), 64'(resp));
  endtask

  // caller fills pkt[0..total-1]; total 0 gives silence
  task automatic do_read(input int k, input int total, input bit exp_err,
                         input int exp_len, input logic [7:0] exp_pid, input string tag);
    logic [6:0]  a;
    logic [3:0]  e;
    logic [31:0] d, lo, hi;
    logic [63:0] bufv;
    setup(k, 8'h69, 8'h00, a, e);
    txn = 0;
    wr(3'd0, 32'h1);
    wait_tx(3);
    check_token(8'h69, a, e);
    if (total > 0) rx_pkt(total);
    wait_done();
    rd(3'd0, d);
    chk({tag, " error flag"}, 64'(d[8]), 64'(exp_err));
    if (!exp_err) chk({tag, " length"}, 64'(d[7:4]), 64'(exp_len));
    rd(3'd1, d);
    chk({tag, " received pid"}, 64'(d[23:16]), 64'(exp_pid));
    if (!exp_err) begin
      rd(3'd2, lo); rd(3'd3, hi);
      bufv = {hi, lo};
      for (int j = 0; j < exp_len; j++)
        chk({tag, " buffer byte"}, 64'(bufv[8*j +: 8]), 64'(pkt[1 + j]));
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values at every address
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset value", 64'(d), (a == 4) ? 64'h17F : 64'h0);
    end
    chk("R11 rx_ready idle", 64'(rx_ready), 64'd0);

    // R2: reserved bits
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); chk("R2 dev reserved bits", 64'(d), 64'h0000_0F7F);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R2 pid reserved bits", 64'(d), 64'h0000_FFFF);
    wr(3'd0, 32'hFFFF_FE0C); rd(3'd0, d); chk("R2 ctrl reserved bits", 64'(d), 64'h0);
    // R5: length saturation
    wr(3'd0, 32'h0000_00F2); rd(3'd0, d); chk("R5 length saturates", 64'(d), 64'h82);

    // R4 R5 R6: write sweep over all lengths, back-pressure on odd lengths
    for (int l = 0; l <= 8; l++) begin
      bp_mode = l[0];
      do_write(l, l, (l == 8) ? 8'h1E : 8'hD2, 1'b0);
    end
    bp_mode = 1'b1;

    // R7: read sweep over all payload sizes
    for (int n = 0; n <= 8; n++) begin
      pkt[0] = n[0] ? 8'h4B : 8'hC3;
      for (int j = 0; j < n + 2; j++) pkt[1 + j] = 8'(n * 11 + j * 29 + 1);
      do_read(n + 20, n + 3, 1'b0, n, pkt[0], "R7");
    end

    // R8: NAK answer
    pkt[0] = 8'h5A;
    do_read(40, 1, 1'b0, 0, 8'h5A, "R8");

    // R9: broken complement on a write handshake, then a good one clears error
    do_write(41, 2, 8'h5B, 1'b1);
    do_write(42, 1, 8'hD2, 1'b0);
    // R9: broken data PID on read, and an over-long data packet
    pkt[0] = 8'hC2; pkt[1] = 8'h11; pkt[2] = 8'h22; pkt[3] = 8'h33;
    do_read(43, 4, 1'b1, 0, 8'hC2, "R9 bad pid");
    pkt[0] = 8'hC3;
    for (int j = 1; j < 12; j++) pkt[j] = 8'(j * 5);
    do_read(44, 12, 1'b1, 0, 8'hC3, "R9 long packet");

    // R10: silence after a read token keeps previous received PID
    do_read(45, 0, 1'b1, 0, 8'hC3, "R10 timeout");

    // R2 R3: writes during a transaction are ignored
    begin
      logic [6:0] a;
      logic [3:0] e;
      setup(46, 8'h69, 8'h4B, a, e);
      txn = 0;
      wr(3'd0, 32'h1);
      wait_tx(3);
      rd(3'd0, d); chk("R3 go reads 1 while busy", 64'(d[0]), 64'd1);
      wr(3'd4, 32'h0000_0A33);
      wr(3'd1, 32'h0000_1234);
      pkt[0] = 8'h5A;
      rx_pkt(1);
      wait_done();
      rd(3'd4, d); chk("R2 dev write ignored while busy", 64'(d), 64'({20'd0, e, 1'b0, a}));
      rd(3'd1, d); chk("R2 pid write ignored while busy", 64'(d), 64'h005A_4B69);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule